// File: doc/BRIEF.md
# Interrupt Routing and Flag Controller

This block connects three interrupt sources to a DSP core: a request from the host microcontroller, a conversion-done event from the A/D converter and a ready event from the D/A converter. A 3-bit routing code chooses one of six fixed assignments of these sources to the three DSP interrupt lines. Each line has its own pending flag. A rising edge on the source routed to a line sets that flag. The DSP clears a flag by writing a one to a clear strobe, and a global enable gates all three lines toward the core.

The block also holds a single flag that signals from the DSP to the host. Only the DSP can raise it, and both sides can read it. The host asks for it to be cleared, but the flag drops only after a fixed number of host instruction completions. This delay keeps the two processors in step at the end of the host's service routine. Each host instruction completion arrives as a one-cycle strobe.

Top module: `irq_router`

## Requirements
- R1: After reset, the global enable is 0, the routing code is 000, all pending flags and the host flag are 0, and every interrupt output is low.
- R2: The DSP control register sits at dsp_addr 0. Bit 0 is the enable, bits 3:1 are the routing code, bits 6:4 are the clear strobes for lines 0..2, and bit 7 sets the host flag. The routing code gives these lines for (host, A/D, D/A): 000 gives (2,1,0), 001 gives (1,2,0), 010 gives (2,0,1), 011 gives (1,0,2), 100 gives (0,2,1) and 101 gives (0,1,2).
- R3: A pending flag is set by a rising edge of its routed source, seen one clock after the edge is sampled. A source that stays high does not set the flag again.
- R4: With routing code 110 or 111, no source sets any flag and all three outputs stay low. Flags that are already set are kept and can be read at dsp_addr 1, bits 2:0.
- R5: Output line i is high exactly when pending flag i is 1, the enable is 1 and the routing code is not reserved.
- R6: Writing 1 to a clear strobe resets the matching pending flag. The strobe bits always read back as 0.
- R7: If a source edge and a clear strobe hit the same flag in the same cycle, the flag ends up set.
- R8: A DSP write with bit 7 set raises the host flag on the next clock. The flag reads as dsp_rdata[7] at address 0 and as host_rdata[0].
- R9: A host write with host_wbit=1 arms a clear. The flag drops on the clock edge that takes the third host_insn_done strobe after the write cycle. A strobe in the write cycle itself does not count.
- R10: Another host clear write during the countdown restarts it from three.
- R11: A DSP set of the host flag cancels any countdown in progress, including one armed in the same cycle, and the flag stays high.
- R12: A host write with host_wbit=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_host | input | 1 | Host-to-DSP request source |
| src_adc | input | 1 | A/D conversion-done source |
| src_dac | input | 1 | D/A ready source |
| dsp_wr | input | 1 | DSP write strobe |
| dsp_addr | input | 1 | DSP register select (0 control, 1 pending) |
| dsp_wdata | input | 8 | DSP write data |
| dsp_rdata | output | 8 | DSP read data for dsp_addr |
| host_wr | input | 1 | Host write strobe to the flag clear location |
| host_wbit | input | 1 | Host write data bit; 1 requests a clear |
| host_insn_done | input | 1 | One-cycle strobe per completed host instruction |
| host_rdata | output | 8 | Host read data; bit 0 is the host flag |
| dsp_int | output | 3 | Gated interrupt lines INT0..INT2 |
| host_irq | output | 1 | DSP-to-host interrupt flag |

## Verification
Two things can land in the same cycle. A source edge and a DSP clear strobe can both target one pending flag. A DSP set of the host flag can also coincide with a running or freshly armed host clear countdown. The bench provokes the first case on purpose by raising a source in the same cycle as a clear write to its routed line, and it provokes the second by re-setting the flag partway through a countdown. Random traffic then produces many more such collisions. Each cycle's outputs are compared with a reference model in which set beats clear and a DSP set cancels the countdown.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int DELAY = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_host,
  input  logic       src_adc,
  input  logic       src_dac,
  input  logic       dsp_wr,
  input  logic       dsp_addr,
  input  logic [7:0] dsp_wdata,
  output logic [7:0] dsp_rdata,
  input  logic       host_wr,
  input  logic       host_wbit,
  input  logic       host_insn_done,
  output logic [7:0] host_rdata,
  output logic [2:0] dsp_int,
  output logic       host_irq
);
  localparam int CW = $clog2(DELAY + 1);

  logic          en;
  logic [2:0]    sel;
  logic [2:0]    pend;
  logic [2:0]    src_q;
  logic          flag;
  logic [CW-1:0] cnt;

  logic [2:0] src, edges, setv, clr;
  logic       ctrl_wr, reserved;
  logic [5:0] lanes;

  function automatic logic [5:0] lane_map(input logic [2:0] code);
    case (code)
      3'd0:    lane_map = {2'd0, 2'd1, 2'd2};
      3'd1:    lane_map = {2'd0, 2'd2, 2'd1};
      3'd2:    lane_map = {2'd1, 2'd0, 2'd2};
      3'd3:    lane_map = {2'd2, 2'd0, 2'd1};
      3'd4:    lane_map = {2'd1, 2'd2, 2'd0};
      3'd5:    lane_map = {2'd2, 2'd1, 2'd0};
      default: lane_map = 6'h3f;
    endcase
  endfunction

  assign src      = {src_dac, src_adc, src_host};
  assign edges    = src & ~src_q;
  assign ctrl_wr  = dsp_wr && !dsp_addr;
  assign clr      = ctrl_wr ? dsp_wdata[6:4] : 3'b000;
  assign reserved = sel[2] & sel[1];
  assign lanes    = lane_map(sel);

  always_comb begin
    setv = 3'b000;
    for (int s = 0; s < 3; s++)
      if (edges[s] && lanes[2*s +: 2] != 2'd3)
        setv[lanes[2*s +: 2]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      sel   <= 3'b000;
      pend  <= 3'b000;
      src_q <= 3'b000;
    end else begin
      src_q <= src;
      pend  <= setv | (pend & ~clr);
      if (ctrl_wr) begin
        en  <= dsp_wdata[0];
        sel <= dsp_wdata[3:1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      cnt  <= '0;
    end else if (ctrl_wr && dsp_wdata[7]) begin
      flag <= 1'b1;
      cnt  <= '0;
    end else if (host_wr && host_wbit) begin
      cnt <= CW'(DELAY);
    end else if (cnt != '0 && host_insn_done) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) flag <= 1'b0;
    end
  end

  assign dsp_int    = (en && !reserved) ? pend : 3'b000;
  assign host_irq   = flag;
  assign host_rdata = {7'b0, flag};
  assign dsp_rdata  = dsp_addr ? {5'b0, pend} : {flag, 3'b000, sel, en};
endmodule

module irq_router_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] dsp_int,
  input logic       host_irq,
  input logic       host_insn_done,
  input logic       dsp_wr,
  input logic       dsp_addr,
  input logic [7:0] dsp_wdata,
  input logic [7:0] dsp_rdata,
  input logic [2:0] pend,
  input logic       en,
  input logic [2:0] sel
);
  assert_line_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((dsp_int & ~pend) == 3'b000) && (en || dsp_int == 3'b000));

  assert_reserved_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel >= 3'd6) |-> dsp_int == 3'b000);

  assert_strobe_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dsp_addr |-> dsp_rdata[6:4] == 3'b000);

  assert_flag_raised_by_dsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> $past(dsp_wr && !dsp_addr && dsp_wdata[7]));

  assert_flag_drop_on_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_irq) |-> $past(host_insn_done));
endmodule

bind irq_router irq_router_checker chk (
  .clk(clk), .rst_n(rst_n), .dsp_int(dsp_int), .host_irq(host_irq),
  .host_insn_done(host_insn_done), .dsp_wr(dsp_wr), .dsp_addr(dsp_addr),
  .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata), .pend(pend), .en(en), .sel(sel)
);

// File: tb/irq_router_test.sv
module irq_router_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_host = 0, src_adc = 0, src_dac = 0;
  logic dsp_wr = 0, dsp_addr = 0;
  logic [7:0] dsp_wdata = 8'h00;
  logic host_wr = 0, host_wbit = 0, host_insn_done = 0;
  logic [7:0] dsp_rdata, host_rdata;
  logic [2:0] dsp_int;
  logic host_irq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_router uut (
    .clk(clk), .rst_n(rst_n), .src_host(src_host), .src_adc(src_adc), .src_dac(src_dac),
    .dsp_wr(dsp_wr), .dsp_addr(dsp_addr), .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata),
    .host_wr(host_wr), .host_wbit(host_wbit), .host_insn_done(host_insn_done),
    .host_rdata(host_rdata), .dsp_int(dsp_int), .host_irq(host_irq)
  );

  logic       m_en, m_flag;
  logic [2:0] m_sel, m_pend, m_prev;
  int         m_cnt;

  function automatic int line_for(input logic [2:0] code, input int source);
    int host_l[6] = '{2, 1, 2, 1, 0, 0};
    int adc_l[6]  = '{1, 2, 0, 0, 2, 1};
    int dac_l[6]  = '{0, 0, 1, 2, 1, 2};
    if (code > 3'd5) return -1;
    if (source == 0) return host_l[code];
    if (source == 1) return adc_l[code];
    return dac_l[code];
  endfunction

  function automatic logic [2:0] exp_int();
    return (m_en && m_sel < 3'd6) ? m_pend : 3'b000;
  endfunction

  function automatic logic [7:0] exp_dsp_rd(input logic a);
    return a ? {5'b0, m_pend} : {m_flag, 3'b000, m_sel, m_en};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_sel = 0; m_pend = 0; m_prev = 0; m_flag = 0; m_cnt = 0;
    end else begin
      logic [2:0] cur, rise, setv, clrv;
      cur  = {src_dac, src_adc, src_host};
      rise = cur & ~m_prev;
      setv = 3'b000;
      for (int s = 0; s < 3; s++) begin
        int ln;
        ln = line_for(m_sel, s);
        if (rise[s] && ln >= 0) setv[ln] = 1'b1;
      end
      clrv = (dsp_wr && !dsp_addr) ? dsp_wdata[6:4] : 3'b000;
      m_pend = setv | (m_pend & ~clrv);
      m_prev = cur;
      if (dsp_wr && !dsp_addr && dsp_wdata[7]) begin
        m_flag = 1; m_cnt = 0;
      end else if (host_wr && host_wbit) begin
        m_cnt = 3;
      end else if (m_cnt > 0 && host_insn_done) begin
        m_cnt--;
        if (m_cnt == 0) m_flag = 0;
      end
      if (dsp_wr && !dsp_addr) begin
        m_en = dsp_wdata[0]; m_sel = dsp_wdata[3:1];
      end
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check("R5 lines", {5'b0, dsp_int}, {5'b0, exp_int()});
    check("R9 host_irq", {7'b0, host_irq}, {7'b0, m_flag});
    check("R8 host_rdata", host_rdata, {7'b0, m_flag});
    check("R6 dsp_rdata", dsp_rdata, exp_dsp_rd(dsp_addr));
  endtask

  task automatic dsp_write(input logic a, input logic [7:0] d);
    dsp_wr = 1; dsp_addr = a; dsp_wdata = d;
    step();
    dsp_wr = 0;
  endtask

  task automatic host_clear(input logic b);
    host_wr = 1; host_wbit = b;
    step();
    host_wr = 0; host_wbit = 0;
  endtask

  task automatic strobe();
    host_insn_done = 1;
    step();
    host_insn_done = 0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    step(); step();
    rst_n = 1;
    step();
    check("R1 lines", {5'b0, dsp_int}, 8'h00);
    check("R1 flag", {7'b0, host_irq}, 8'h00);
    check("R1 ctrl", dsp_rdata, 8'h00);

    dsp_write(0, 8'h09);
    src_adc = 1; step();
    check("R2 adc->INT2 code100", {5'b0, dsp_int}, 8'h04);
    dsp_write(0, 8'h49);
    check("R6 cleared", {5'b0, dsp_int}, 8'h00);
    check("R6 strobe readback", {5'b0, dsp_rdata[6:4]}, 8'h00);
    step();
    check("R3 level no reset", {5'b0, dsp_int}, 8'h00);

    src_dac = 1; dsp_wr = 1; dsp_addr = 0; dsp_wdata = 8'h29;
    step(); dsp_wr = 0;
    check("R7 set wins", {5'b0, dsp_int}, 8'h02);

    dsp_write(0, 8'h0D);
    check("R4 reserved outputs low", {5'b0, dsp_int}, 8'h00);
    src_host = 1; dsp_addr = 1; step();
    check("R4 reserved no routing", dsp_rdata, 8'h02);

    dsp_write(0, 8'h0A);
    check("R5 disabled", {5'b0, dsp_int}, 8'h00);
    dsp_write(0, 8'h0B);
    check("R5 enabled", {5'b0, dsp_int}, 8'h02);
    dsp_write(0, 8'h7B);
    src_host = 0; src_adc = 0; src_dac = 0; step();

    dsp_write(0, 8'h80);
    check("R8 host view", host_rdata, 8'h01);
    check("R8 dsp view", {7'b0, dsp_rdata[7]}, 8'h01);
    host_clear(0); step();
    check("R12 zero write", {7'b0, host_irq}, 8'h01);
    host_clear(1); strobe(); strobe();
    check("R9 after two", {7'b0, host_irq}, 8'h01);
    strobe();
    check("R9 after three", {7'b0, host_irq}, 8'h00);

    dsp_write(0, 8'h80);
    host_clear(1); strobe(); strobe();
    host_clear(1); strobe(); strobe();
    check("R10 restarted", {7'b0, host_irq}, 8'h01);
    strobe();
    check("R10 drop", {7'b0, host_irq}, 8'h00);

    dsp_write(0, 8'h80);
    host_clear(1); strobe();
    dsp_write(0, 8'h80);
    strobe(); strobe(); strobe();
    check("R11 cancelled", {7'b0, host_irq}, 8'h01);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(3) == 0) src_host = ~src_host;
      if ($urandom_range(3) == 0) src_adc  = ~src_adc;
      if ($urandom_range(3) == 0) src_dac  = ~src_dac;
      dsp_wr = ($urandom_range(5) == 0);
      dsp_addr = $urandom_range(1);
      dsp_wdata = 8'($urandom);
      if ($urandom_range(3) != 0) dsp_wdata[7] = 1'b0;
      host_wr = ($urandom_range(9) == 0);
      host_wbit = $urandom_range(1);
      host_insn_done = ($urandom_range(2) == 0);
      step();
    end
    dsp_wr = 0; host_wr = 0; host_insn_done = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule